// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block forms the word a NOR-style flash returns on a read while an embedded program or erase is running. The word depends on the operation the device is running. It also depends on whether the read address falls in the sector that is being erased or is suspended. Three bit positions carry status: bit 7 is a polarity bit, bit 6 is a busy toggle and bit 2 is a sector toggle. A separate ready/busy line shows whether an embedded algorithm is active.

The operation state arrives from outside as a 3-bit code: 0 idle, 1 program, 2 erase, 3 erase-suspended, 4 program during suspend. The other inputs are the sector under erase or suspend, the data bit being programmed, a read strobe, the sector field of the read address, a count of write-strobe rising edges for the current command, and the array read data. The output word is combinational on the current inputs and the two toggle flops. A read strobe advances the flops at the clock edge that ends the read cycle.

Top module: `flash_status_gen`

## Requirements
- R1: With the state idle (code 0), the output word equals the array data and ready/busy is 1.
- R2: During a program (code 1), bit 7 is the complement of the programmed bit, bit 2 holds steady at 0, and ready/busy is 0.
- R3: In every busy state (codes 1, 2 and 4), bit 6 inverts between successive read cycles. Clock cycles without a read strobe leave it unchanged. Once the state returns to idle, bit 6 shows array data again.
- R4: Entering a busy state from a different state clears both toggle flops, so the first status read of the new operation shows bit 6 = 0.
- R5: During an erase (code 2) with at least 6 write-strobe edges counted, bit 7 reads 0, bits 6 and 2 toggle, and ready/busy is 0.
- R6: During an erase whose write-strobe edge count is below 6, bits 6 and 2 read 0 and reads do not advance either toggle.
- R7: The bit 2 toggle advances only on reads whose sector matches the erased or suspended sector. A read of another sector during an erase shows the current bit 2 value and leaves it unchanged.
- R8: In erase-suspend (code 3), a read of the suspended sector gives bit 7 = 1 and bit 6 = 1, bit 2 toggles, and ready/busy is 1.
- R9: In erase-suspend, a read of any other sector returns the array data on every bit, and ready/busy is 1.
- R10: During a program in suspend (code 4), bit 7 is the complemented programmed bit, bit 6 toggles, bit 2 carries array bit 2, and ready/busy is 0.
- R11: Bits other than 7, 6 and 2 always carry the array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opState | input | 3 | Operation state code |
| sectAddr | input | SECT_W | Sector being erased or suspended |
| progBit | input | 1 | Data bit 7 of the word being programmed |
| rdStrobe | input | 1 | Read cycle active this clock |
| rdSector | input | SECT_W | Sector field of the read address |
| weEdgeCnt | input | CNT_W | Write-strobe rising edges counted for the current command |
| arrayData | input | DATA_W | Array read data |
| dataOut | output | DATA_W | Read word with status bits substituted |
| readyBusy | output | 1 | 1 when no embedded algorithm runs |

## Verification
The hardest case to reach is the interaction between the two toggles and the sector match. In an erase, reads of a foreign sector must advance bit 6 but freeze bit 2. A later suspend must keep the bit 2 phase while bit 6 is forced high. The stimulus drives an erase through the edge-count threshold, then interleaves reads across every sector and moves into suspend and program-in-suspend. The expected value of each toggle is tracked in the bench and compared at every read.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_PROG      = 3'd1,
    OP_ERASE     = 3'd2,
    OP_SUSP      = 3'd3,
    OP_SUSP_PROG = 3'd4
  } opState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrTog;      // new operation: clear both toggles
    logic advT6;       // advance busy toggle
    logic advT2;       // advance sector toggle
    logic selProg;     // program view
    logic selErase;    // erase view
    logic selSusp;     // suspended-sector view
    logic selSuspProg; // program-in-suspend view
    logic statValid;   // erase status valid (edge count reached)
  } ctlStrobes_t;

endpackage

// File: rtl/flash_status_ctl.sv
module flash_status_ctl
  import flash_status_pkg::*;
#(
  parameter int SECT_W        = 2,
  parameter int CNT_W         = 3,
  parameter int VALID_STROBES = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opState,
  input  logic [SECT_W-1:0] sectAddr,
  input  logic              rdStrobe,
  input  logic [SECT_W-1:0] rdSector,
  input  logic [CNT_W-1:0]  weEdgeCnt,
  output ctlStrobes_t       strobes,
  output logic              readyBusy
);

  localparam logic [CNT_W-1:0] VALID_CNT = CNT_W'(VALID_STROBES);

  opState_e curState;
  opState_e prevState;
  logic     busy;
  logic     sectHit;
  logic     eraseValid;

  assign curState   = opState_e'(opState);
  assign busy       = (curState == OP_PROG) || (curState == OP_ERASE) ||
                      (curState == OP_SUSP_PROG);
  assign sectHit    = (rdSector == sectAddr);
  assign eraseValid = (weEdgeCnt >= VALID_CNT);
  assign readyBusy  = !busy;

  always_ff @(posedge clk) begin
    if (!rstN) prevState <= OP_IDLE;
    else       prevState <= curState;
  end

  always_comb begin
    strobes             = '0;
    strobes.clrTog      = busy && (curState != prevState);
    strobes.statValid   = eraseValid;
    strobes.selProg     = (curState == OP_PROG);
    strobes.selErase    = (curState == OP_ERASE);
    strobes.selSusp     = (curState == OP_SUSP) && sectHit;
    strobes.selSuspProg = (curState == OP_SUSP_PROG);
    strobes.advT6       = rdStrobe && busy &&
                          ((curState != OP_ERASE) || eraseValid);
    strobes.advT2       = rdStrobe && sectHit &&
                          (((curState == OP_ERASE) && eraseValid) ||
                           (curState == OP_SUSP));
  end

  AST_EARLY_ERASE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    ((curState == OP_ERASE) && (weEdgeCnt < VALID_CNT)) |-> (!strobes.advT6 && !strobes.advT2)); // R6

  AST_ONE_VIEW: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.selProg, strobes.selErase, strobes.selSusp, strobes.selSuspProg})); // R9

endmodule

// File: rtl/flash_status_dp.sv
module flash_status_dp
  import flash_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic              progBit,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut
);

  localparam int POL_BIT  = 7;
  localparam int BUSY_BIT = 6;
  localparam int SECT_BIT = 2;

  logic togBusy;
  logic togSect;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      togBusy <= 1'b0;
      togSect <= 1'b0;
    end else if (strobes.clrTog) begin
      togBusy <= 1'b0;
      togSect <= 1'b0;
    end else begin
      if (strobes.advT6) togBusy <= ~togBusy;
      if (strobes.advT2) togSect <= ~togSect;
    end
  end

  always_comb begin
    dataOut = arrayData;
    if (strobes.selProg) begin
      dataOut[POL_BIT]  = ~progBit;
      dataOut[BUSY_BIT] = togBusy;
      dataOut[SECT_BIT] = togSect;
    end else if (strobes.selErase) begin
      dataOut[POL_BIT]  = 1'b0;
      dataOut[BUSY_BIT] = strobes.statValid & togBusy;
      dataOut[SECT_BIT] = strobes.statValid & togSect;
    end else if (strobes.selSusp) begin
      dataOut[POL_BIT]  = 1'b1;
      dataOut[BUSY_BIT] = 1'b1;
      dataOut[SECT_BIT] = togSect;
    end else if (strobes.selSuspProg) begin
      dataOut[POL_BIT]  = ~progBit;
      dataOut[BUSY_BIT] = togBusy;
    end
  end

  AST_BUSY_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advT6 && !strobes.clrTog) |=> (togBusy != $past(togBusy))); // R3

  AST_TOGGLES_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrTog |=> (!togBusy && !togSect)); // R4

  AST_SECT_TOGGLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advT2 && !strobes.clrTog) |=> $stable(togSect)); // R7

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int SECT_W        = 2,
  parameter int CNT_W         = 3,
  parameter int VALID_STROBES = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opState,
  input  logic [SECT_W-1:0] sectAddr,
  input  logic              progBit,
  input  logic              rdStrobe,
  input  logic [SECT_W-1:0] rdSector,
  input  logic [CNT_W-1:0]  weEdgeCnt,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut,
  output logic              readyBusy
);

  localparam logic [DATA_W-1:0] STATUS_MASK = DATA_W'(8'hC4);

  ctlStrobes_t strobes;

  flash_status_ctl #(
    .SECT_W(SECT_W), .CNT_W(CNT_W), .VALID_STROBES(VALID_STROBES)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .opState(opState), .sectAddr(sectAddr),
    .rdStrobe(rdStrobe), .rdSector(rdSector), .weEdgeCnt(weEdgeCnt),
    .strobes(strobes), .readyBusy(readyBusy)
  );

  flash_status_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .progBit(progBit),
    .arrayData(arrayData), .dataOut(dataOut)
  );

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (opState == 3'd0) |-> ((dataOut == arrayData) && readyBusy)); // R1

  AST_SUSP_SECTOR_VIEW: assert property (@(posedge clk) disable iff (!rstN)
    ((opState == 3'd3) && (rdSector == sectAddr)) |-> (dataOut[7] && dataOut[6] && readyBusy)); // R8

  AST_PLAIN_BITS: assert property (@(posedge clk) disable iff (!rstN)
    ((dataOut & ~STATUS_MASK) == (arrayData & ~STATUS_MASK))); // R11

endmodule

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] opState = 3'd0;
  logic [1:0] sectAddr = 2'd0;
  logic       progBit = 1'b0;
  logic       rdStrobe = 1'b0;
  logic [1:0] rdSector = 2'd0;
  logic [2:0] weEdgeCnt = 3'd0;
  logic [7:0] arrayData = 8'h00;
  logic [7:0] dataOut;
  logic       readyBusy;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model of the two toggles
  bit mT6 = 1'b0;
  bit mT2 = 1'b0;
  logic [2:0] mState = 3'd0;

  always #4 clk = ~clk;

  flash_status_gen dut_i (
    .clk(clk), .rstN(rstN), .opState(opState), .sectAddr(sectAddr),
    .progBit(progBit), .rdStrobe(rdStrobe), .rdSector(rdSector),
    .weEdgeCnt(weEdgeCnt), .arrayData(arrayData), .dataOut(dataOut),
    .readyBusy(readyBusy)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string reqOf(logic [2:0] st, bit hit, bit valid);
    case (st)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return valid ? (hit ? "R5" : "R7") : "R6";
      3'd3: return hit ? "R8" : "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic bit isBusy(logic [2:0] st);
    return (st == 3'd1) || (st == 3'd2) || (st == 3'd4);
  endfunction

  task automatic setState(logic [2:0] st, logic [1:0] sect, logic [2:0] cnt, bit pb);
    @(negedge clk);
    rdStrobe  = 1'b0;
    opState   = st;
    sectAddr  = sect;
    weEdgeCnt = cnt;
    progBit   = pb;
    if (isBusy(st) && st != mState) begin mT6 = 1'b0; mT2 = 1'b0; end  // R4
    mState = st;
    @(posedge clk);
  endtask

  task automatic quietCycle();
    @(negedge clk);
    rdStrobe = 1'b0;
    @(posedge clk);
  endtask

  task automatic doRead(logic [1:0] sect, logic [7:0] arr);
    bit hit;
    bit valid;
    logic [7:0] exp;
    logic expRb;
    @(negedge clk);
    rdSector  = sect;
    arrayData = arr;
    rdStrobe  = 1'b1;
    hit   = (sect == sectAddr);
    valid = (weEdgeCnt >= 3'd6);
    exp   = arr;
    expRb = !isBusy(opState);
    case (opState)
      3'd1: begin exp[7] = ~progBit; exp[6] = mT6; exp[2] = mT2; end
      3'd2: begin exp[7] = 1'b0; exp[6] = valid & mT6; exp[2] = valid & mT2; end
      3'd3: if (hit) begin exp[7] = 1'b1; exp[6] = 1'b1; exp[2] = mT2; end
      3'd4: begin exp[7] = ~progBit; exp[6] = mT6; end
      default: ;
    endcase
    #1;
    chk(reqOf(opState, hit, valid), dataOut, exp);
    chk({reqOf(opState, hit, valid), " ready/busy"}, {7'd0, readyBusy}, {7'd0, expRb});
    chk("R11", dataOut & 8'h3B, arr & 8'h3B);
    @(posedge clk);
    if (isBusy(opState) && (opState != 3'd2 || valid)) mT6 = ~mT6;  // R3
    if (hit && ((opState == 3'd2 && valid) || opState == 3'd3)) mT2 = ~mT2;
    #1 rdStrobe = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    arrayData = 8'hA5;
    #1;
    chk("R1 reset", dataOut, 8'hA5);
    chk("R1 reset ready", {7'd0, readyBusy}, 8'd1);

    // idle sweep
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 8; k++) doRead(2'(s), 8'(s * 53 + k * 29 + 7));

    // program, both data polarities, with quiet cycles in between
    for (int pb = 0; pb < 2; pb++) begin
      setState(3'd1, 2'd1, 3'd4, 1'(pb));
      for (int k = 0; k < 6; k++) begin
        doRead(2'(k % 4), 8'(k * 71 + 3));
        if (k == 2) begin quietCycle(); quietCycle(); end
      end
      setState(3'd0, 2'd1, 3'd0, 1'(pb));
      doRead(2'd0, 8'h5A);  // R3 stops toggling
      doRead(2'd0, 8'h5A);
    end

    // erase: below the edge threshold, then past it
    for (int sect = 0; sect < 4; sect++) begin
      setState(3'd2, 2'(sect), 3'd4, 1'b0);
      for (int k = 0; k < 4; k++) doRead(2'(k), 8'(k * 19 + sect));
      setState(3'd2, 2'(sect), 3'd5, 1'b0);
      doRead(2'(sect), 8'hFF);
      setState(3'd2, 2'(sect), 3'd6, 1'b0);
      for (int k = 0; k < 12; k++) doRead(2'((k * 3) % 4), 8'(k * 37 + sect * 5));
      setState(3'd2, 2'(sect), 3'd7, 1'b0);
      for (int k = 0; k < 3; k++) doRead(2'(sect), 8'(k * 11));

      // suspend the same sector
      setState(3'd3, 2'(sect), 3'd7, 1'b0);
      for (int k = 0; k < 10; k++) doRead(2'((k + sect) % 4), 8'(k * 41 + 1));

      // program during suspend
      setState(3'd4, 2'(sect), 3'd4, 1'(sect % 2));
      for (int k = 0; k < 6; k++) doRead(2'(k % 4), 8'(k * 23 + 2));
      setState(3'd0, 2'(sect), 3'd0, 1'b0);
      doRead(2'(sect), 8'h3C);
    end

    // back-to-back operations: switching busy states clears the toggles
    setState(3'd1, 2'd2, 3'd4, 1'b1);
    doRead(2'd2, 8'h00);
    setState(3'd2, 2'd2, 3'd6, 1'b0);
    doRead(2'd2, 8'h00);  // R4 first erase read shows bit 6 = 0
    doRead(2'd2, 8'h00);
    setState(3'd0, 2'd2, 3'd0, 1'b0);
    doRead(2'd3, 8'h81);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule